// File: doc/BRIEF.md
# Bus-Mapped Board Control Register Bank

This block is an 8-bit register bank that hangs off a simple asynchronous I/O bus. The bus carries a latched address, an active-low write-select, a data strobe and a split data path: data in, data out, and an output enable for the tristate pad. The bank holds three read/write control registers. Each one has its own power-up pattern and its own set of writable bits. The bank also holds three read-only status registers that show live board input pins.

A cycle belongs to the bank only when three things hold: the cycle-qualifier lines match, address bits 5 to 17 are all zero, and address bits 1 to 4 carry a known register code. Writes are captured once per strobe, after the strobe has been synchronised into the local clock. On a read, the bank drives the data bus only while it is the target and the synchronised strobe is high. It releases the bus for every other device on the segment.

Top module: `board_ctl_regs`

## Requirements
- R1: After reset, the control outputs read as follows, with bit k = data[k]. Control 1 is 8'h09 (bits 0 and 3 set). Control 2 is 8'h40 (bit 6). Configuration control is 8'h1F (bits 0 to 4).
- R2: Unused bits are never written and always read 0. This covers control 1 bit 2, control 2 bit 7 and configuration control bits 5 to 7. Writing 8'hFF therefore yields 8'hFB, 8'h7F and 8'h1F.
- R3: The register code is {addr[1],addr[2],addr[3],addr[4]}. The codes are: 4'b0000 control 1, 4'b1000 control 2, 4'b1010 configuration control, 4'b0100 status 1, 4'b1100 status 2, 4'b1110 configuration status.
- R4: The bank is selected only when bus_addr[17:5] is all zero. A write with any other block field, such as bit 10 set, or bits 10 and 17 set, leaves every control register unchanged.
- R5: A read aimed at another block field leaves bus_data_oe low.
- R6: A write happens when bus_write_n is low during a strobe. A strobe with bus_write_n high is a read: it drives the selected register onto bus_data_out with bus_data_oe high, and it changes nothing.
- R7: Status registers are read-only and return the current pin levels. A write to a status code changes no control register.
- R8: Status field layout is as follows. Status 1 = {dev1_stat, dev0_stat}. Status 2 = {3'b0, dac_last, crate_stat}. Configuration status = {2'b0, cfg_done, cfg_busy, cfg_init}.
- R9: An access is ignored unless all three qualifiers hold: bus_am equals AM_CODE (6'b100111), bus_geo_n equals GEO_N_SLOT (5'b10000), and bus_iack_n equals IACK_N_OK (0). An ignored access neither writes nor drives.
- R10: Write data is captured on the first clock edge after the synchronised strobe rises. Changes on bus_data_in later in the same strobe are not captured.
- R11: A register code not listed in R3, used inside the bank, is neither written nor driven.
- R12: Asserting rst_n low in mid-run restores every control register to its R1 value.
- R13: bus_data_oe rises only two clock edges after the strobe is seen high. It drops again once the synchronised strobe falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low system reset (async) |
| bus_iack_n | input | 1 | Interrupt-acknowledge line, part of the cycle qualifier |
| bus_am | input | 6 | Address-modifier code |
| bus_geo_n | input | 5 | Geographic slot address, active low |
| bus_addr | input | 17 | Latched address, bits 17..1 |
| bus_write_n | input | 1 | Active-low write select |
| bus_strobe | input | 1 | Asynchronous data strobe, active high |
| bus_data_in | input | 8 | Data from the bus pad |
| bus_data_out | output | 8 | Read data toward the pad |
| bus_data_oe | output | 1 | Pad output enable |
| dev0_stat | input | 4 | Status pins of device 0 |
| dev1_stat | input | 4 | Status pins of device 1 |
| crate_stat | input | 4 | Crate status pins |
| dac_last | input | 1 | Last DAC output flag |
| cfg_init | input | 2 | Per-device init flags |
| cfg_busy | input | 2 | Per-device busy flags |
| cfg_done | input | 2 | Per-device done flags |
| ctrl1_q | output | 8 | Control register 1 |
| ctrl2_q | output | 8 | Control register 2 |
| cfg_ctrl_q | output | 8 | Configuration control register |

## Verification
The assertions assume that bus_addr, bus_write_n and the qualifier lines hold steady from the moment the strobe rises until the synchronised strobe has fallen again. A register change is therefore traced back to the write-select and the block field one cycle earlier. The stimulus keeps to this rule. Every access sets the address and direction on a falling edge, raises the strobe in the same step, and holds them for four idle cycles after the strobe drops. Only bus_data_in is moved inside a strobe, and only to exercise R10.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;
  localparam int DW       = 8;
  localparam int NUM_CTRL = 3;
  localparam int SEL_W    = 4;
  localparam int ADDR_HI  = 17;
  localparam int BLK_LO   = 5;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_C1, SRC_C2, SRC_CC, SRC_S1, SRC_S2, SRC_CS
  } src_e;

  // register codes, written as {addr[1],addr[2],addr[3],addr[4]}
  localparam logic [SEL_W-1:0] SEL_C1 = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_C2 = 4'b1000;
  localparam logic [SEL_W-1:0] SEL_CC = 4'b1010;
  localparam logic [SEL_W-1:0] SEL_S1 = 4'b0100;
  localparam logic [SEL_W-1:0] SEL_S2 = 4'b1100;
  localparam logic [SEL_W-1:0] SEL_CS = 4'b1110;

  localparam byte_t CTRL_RST  [NUM_CTRL] = '{8'h09, 8'h40, 8'h1F};
  localparam byte_t CTRL_MASK [NUM_CTRL] = '{8'hFB, 8'h7F, 8'h1F};
  localparam logic [SEL_W-1:0] CTRL_SEL [NUM_CTRL] = '{SEL_C1, SEL_C2, SEL_CC};
endpackage

// File: rtl/bank_qualify.sv
module bank_qualify
  import board_ctl_pkg::*;
#(
  parameter logic [5:0] AM_CODE    = 6'b100111,
  parameter logic [4:0] GEO_N_SLOT = 5'b10000,
  parameter logic       IACK_N_OK  = 1'b0
) (
  input  logic               iack_n,
  input  logic [5:0]         am,
  input  logic [4:0]         geo_n,
  input  logic [ADDR_HI:1]   addr,
  output logic               hit,
  output logic [SEL_W-1:0]   sel,
  output src_e               src
);
  logic qual_ok;
  logic blk_zero;

  assign qual_ok  = (am == AM_CODE) && (geo_n == GEO_N_SLOT) && (iack_n == IACK_N_OK);
  assign blk_zero = (addr[ADDR_HI:BLK_LO] == '0);
  assign hit      = qual_ok && blk_zero;
  assign sel      = {addr[1], addr[2], addr[3], addr[4]};

  always_comb begin
    unique case (sel)
      SEL_C1:  src = SRC_C1;
      SEL_C2:  src = SRC_C2;
      SEL_CC:  src = SRC_CC;
      SEL_S1:  src = SRC_S1;
      SEL_S2:  src = SRC_S2;
      SEL_CS:  src = SRC_CS;
      default: src = SRC_NONE;
    endcase
  end
endmodule

// File: rtl/bank_strobe_sync.sv
module bank_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], strobe};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] && !last;
endmodule

// File: rtl/bank_ctrl_regs.sv
module bank_ctrl_regs
  import board_ctl_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [SEL_W-1:0]              sel,
  input  byte_t                         wdata,
  output logic [NUM_CTRL-1:0][DW-1:0]   q
);
  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= CTRL_RST[i];
      else if (wr_en && (sel == CTRL_SEL[i]))
        q[i] <= wdata & CTRL_MASK[i];
    end
  end
endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter logic [5:0] AM_CODE    = 6'b100111,
  parameter logic [4:0] GEO_N_SLOT = 5'b10000,
  parameter logic       IACK_N_OK  = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_iack_n,
  input  logic [5:0]  bus_am,
  input  logic [4:0]  bus_geo_n,
  input  logic [17:1] bus_addr,
  input  logic        bus_write_n,
  input  logic        bus_strobe,
  input  logic [7:0]  bus_data_in,
  output logic [7:0]  bus_data_out,
  output logic        bus_data_oe,
  input  logic [3:0]  dev0_stat,
  input  logic [3:0]  dev1_stat,
  input  logic [3:0]  crate_stat,
  input  logic        dac_last,
  input  logic [1:0]  cfg_init,
  input  logic [1:0]  cfg_busy,
  input  logic [1:0]  cfg_done,
  output logic [7:0]  ctrl1_q,
  output logic [7:0]  ctrl2_q,
  output logic [7:0]  cfg_ctrl_q
);
  logic                        hit;
  logic [SEL_W-1:0]            sel;
  src_e                        src;
  logic                        stb_level;
  logic                        stb_rise;
  logic                        wr_en;
  logic [NUM_CTRL-1:0][DW-1:0] ctrl;
  byte_t                       rd_mux;

  bank_qualify #(
    .AM_CODE(AM_CODE), .GEO_N_SLOT(GEO_N_SLOT), .IACK_N_OK(IACK_N_OK)
  ) u_qual (
    .iack_n(bus_iack_n), .am(bus_am), .geo_n(bus_geo_n), .addr(bus_addr),
    .hit(hit), .sel(sel), .src(src)
  );

  bank_strobe_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe(bus_strobe),
    .level(stb_level), .rise(stb_rise)
  );

  assign wr_en = stb_rise && hit && !bus_write_n;

  bank_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel),
    .wdata(bus_data_in), .q(ctrl)
  );

  always_comb begin
    unique case (src)
      SRC_C1:  rd_mux = ctrl[0];
      SRC_C2:  rd_mux = ctrl[1];
      SRC_CC:  rd_mux = ctrl[2];
      SRC_S1:  rd_mux = {dev1_stat, dev0_stat};
      SRC_S2:  rd_mux = {3'b000, dac_last, crate_stat};
      SRC_CS:  rd_mux = {2'b00, cfg_done, cfg_busy, cfg_init};
      default: rd_mux = '0;
    endcase
  end

  assign bus_data_oe  = stb_level && hit && bus_write_n && (src != SRC_NONE);
  assign bus_data_out = bus_data_oe ? rd_mux : '0;

  assign ctrl1_q    = ctrl[0];
  assign ctrl2_q    = ctrl[1];
  assign cfg_ctrl_q = ctrl[2];
endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [17:1] bus_addr,
  input logic        bus_write_n,
  input logic        bus_strobe,
  input logic        bus_data_oe,
  input logic [7:0]  ctrl1_q,
  input logic [7:0]  ctrl2_q,
  input logic [7:0]  cfg_ctrl_q
);
  // R5: drive only when this bank's block field is on the bus and it is a read
  a_r5_oe_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> (bus_addr[17:5] == '0) && bus_write_n);

  // R13: output enable follows the strobe through the synchroniser
  a_r13_oe_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> $past(bus_strobe, 2));

  // R2: unused bits stay zero
  a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl1_q[2] == 1'b0) && (ctrl2_q[7] == 1'b0) && (cfg_ctrl_q[7:5] == 3'b000));

  // R4 / R6: a control register moves only after a write aimed at this block
  a_r4_c1_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl1_q) |-> !$past(bus_write_n) && ($past(bus_addr[17:5]) == '0));
  a_r4_c2_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl2_q) |-> !$past(bus_write_n) && ($past(bus_addr[17:5]) == '0));
  a_r6_cc_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_ctrl_q) |-> !$past(bus_write_n) && ($past(bus_addr[17:5]) == '0));
endmodule

bind board_ctl_regs board_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_write_n(bus_write_n),
  .bus_strobe(bus_strobe), .bus_data_oe(bus_data_oe),
  .ctrl1_q(ctrl1_q), .ctrl2_q(ctrl2_q), .cfg_ctrl_q(cfg_ctrl_q)
);

// File: tb/sim_board_ctl_regs.sv
`timescale 1ns/1ps
module sim_board_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_iack_n = 1'b0;
  logic [5:0]  bus_am = 6'b100111;
  logic [4:0]  bus_geo_n = 5'b10000;
  logic [17:1] bus_addr = '0;
  logic        bus_write_n = 1'b1;
  logic        bus_strobe = 1'b0;
  logic [7:0]  bus_data_in = '0;
  logic [7:0]  bus_data_out;
  logic        bus_data_oe;
  logic [3:0]  dev0_stat = 4'h3, dev1_stat = 4'hA, crate_stat = 4'h9;
  logic        dac_last = 1'b0;
  logic [1:0]  cfg_init = 2'b11, cfg_busy = 2'b00, cfg_done = 2'b11;
  logic [7:0]  ctrl1_q, ctrl2_q, cfg_ctrl_q;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] exp_c [3];

  always #10 clk = ~clk;

  board_ctl_regs u0 (.*);

  localparam logic [3:0] CODES [6] = '{4'b0000, 4'b1000, 4'b1010, 4'b0100, 4'b1100, 4'b1110};
  localparam logic [7:0] RSTV  [3] = '{8'h09, 8'h40, 8'h1F};
  localparam logic [7:0] MASKV [3] = '{8'hFB, 8'h7F, 8'h1F};
  localparam logic [12:0] BLK_DEV0 = 13'h0020;
  localparam logic [12:0] BLK_DEV1 = 13'h1020;

  function automatic logic [17:1] mk_addr(input logic [3:0] code, input logic [12:0] blk);
    logic [17:1] a;
    a = '0;
    a[1] = code[3]; a[2] = code[2]; a[3] = code[1]; a[4] = code[0];
    a[17:5] = blk;
    return a;
  endfunction

  function automatic int ctrl_idx(input logic [3:0] code);
    for (int i = 0; i < 3; i++) if (code == CODES[i]) return i;
    return -1;
  endfunction

  function automatic bit known(input logic [3:0] code);
    for (int i = 0; i < 6; i++) if (code == CODES[i]) return 1;
    return 0;
  endfunction

  function automatic logic [7:0] exp_read(input logic [3:0] code);
    case (code)
      4'b0000: return exp_c[0];
      4'b1000: return exp_c[1];
      4'b1010: return exp_c[2];
      4'b0100: return {dev1_stat, dev0_stat};
      4'b1100: return {3'b000, dac_last, crate_stat};
      4'b1110: return {2'b00, cfg_done, cfg_busy, cfg_init};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_ctrl(input string req);
    check(req, ctrl1_q, exp_c[0]);
    check(req, ctrl2_q, exp_c[1]);
    check(req, cfg_ctrl_q, exp_c[2]);
  endtask

  // one strobe; rd/oe sampled mid-strobe; optional data flip late in strobe
  task automatic access(input logic [3:0] code, input logic [12:0] blk, input bit wr,
                        input logic [7:0] wdata, input bit flip,
                        output logic [7:0] rd, output logic oe);
    @(negedge clk);
    bus_addr = mk_addr(code, blk);
    bus_write_n = !wr;
    bus_data_in = wdata;
    bus_strobe = 1'b1;
    repeat (4) @(negedge clk);
    rd = bus_data_out;
    oe = bus_data_oe;
    if (flip) bus_data_in = ~wdata;
    repeat (2) @(negedge clk);
    bus_strobe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic model_write(input logic [3:0] code, input logic [12:0] blk, input logic [7:0] d);
    int k;
    k = ctrl_idx(code);
    if (blk == '0 && k >= 0) exp_c[k] = d & MASKV[k];
  endtask

  initial begin
    logic [7:0] rd;
    logic oe;
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) exp_c[i] = RSTV[i];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    check_ctrl("R1 reset");
    check("R13 idle oe", bus_data_oe, 1'b0);

    // R2 / R3 / R6 all-ones and all-zeros per control register
    for (int k = 0; k < 3; k++) begin
      access(CODES[k], '0, 1, 8'hFF, 0, rd, oe);
      model_write(CODES[k], '0, 8'hFF);
      check_ctrl("R2 write ones");
      access(CODES[k], '0, 0, 8'h00, 0, rd, oe);
      check("R6 read oe", oe, 1'b1);
      check("R3 read back ones", rd, MASKV[k]);
      check_ctrl("R6 read changes nothing");
      check("R13 oe released", bus_data_oe, 1'b0);
      access(CODES[k], '0, 1, 8'h00, 0, rd, oe);
      model_write(CODES[k], '0, 8'h00);
      access(CODES[k], '0, 0, 8'h00, 0, rd, oe);
      check("R2 read back zeros", rd, 8'h00);
    end

    // R7 / R8 status levels
    dev0_stat = 4'hF; dev1_stat = 4'hF; crate_stat = 4'hF; dac_last = 1;
    cfg_init = 2'b11; cfg_busy = 2'b11; cfg_done = 2'b11;
    access(4'b0100, '0, 0, 0, 0, rd, oe); check("R7 status1 high", rd, 8'hFF);
    access(4'b1100, '0, 0, 0, 0, rd, oe); check("R8 status2 high", rd, 8'h1F);
    access(4'b1110, '0, 0, 0, 0, rd, oe); check("R8 cfg status high", rd, 8'h3F);
    dev0_stat = 4'h0; dev1_stat = 4'h0; crate_stat = 4'h0; dac_last = 0;
    cfg_init = 2'b00; cfg_busy = 2'b00; cfg_done = 2'b00;
    access(4'b0100, '0, 0, 0, 0, rd, oe); check("R7 status1 low", rd, 8'h00);
    check("R7 status1 oe", oe, 1'b1);
    dev0_stat = 4'h5; dev1_stat = 4'hC; crate_stat = 4'h6; dac_last = 1;
    cfg_init = 2'b01; cfg_busy = 2'b10; cfg_done = 2'b11;
    access(4'b0100, '0, 0, 0, 0, rd, oe); check("R8 status1 layout", rd, 8'hC5);
    access(4'b1100, '0, 0, 0, 0, rd, oe); check("R8 status2 layout", rd, 8'h16);
    access(4'b1110, '0, 0, 0, 0, rd, oe); check("R8 cfg status layout", rd, 8'h39);
    access(4'b0100, '0, 1, 8'hAA, 0, rd, oe);
    check_ctrl("R7 status write ignored");

    // R4 / R5 other devices
    access(4'b0000, BLK_DEV0, 1, 8'hF6, 0, rd, oe); check_ctrl("R4 dev0 write");
    access(4'b1000, BLK_DEV1, 1, 8'h3C, 0, rd, oe); check_ctrl("R4 dev1 write");
    access(4'b0000, BLK_DEV0, 0, 0, 0, rd, oe); check("R5 dev0 read oe", oe, 1'b0);
    access(4'b1110, BLK_DEV1, 0, 0, 0, rd, oe); check("R5 dev1 read oe", oe, 1'b0);

    // R9 qualifier
    bus_am = 6'b001001;
    access(4'b0000, '0, 1, 8'hFF, 0, rd, oe); check_ctrl("R9 bad am write");
    access(4'b0000, '0, 0, 0, 0, rd, oe); check("R9 bad am read oe", oe, 1'b0);
    bus_am = 6'b100111; bus_geo_n = 5'b01111;
    access(4'b1000, '0, 1, 8'hFF, 0, rd, oe); check_ctrl("R9 bad geo write");
    bus_geo_n = 5'b10000; bus_iack_n = 1'b1;
    access(4'b1010, '0, 1, 8'hFF, 0, rd, oe); check_ctrl("R9 bad iack write");
    bus_iack_n = 1'b0;

    // R10 single capture per strobe
    access(4'b0000, '0, 1, 8'h81, 1, rd, oe);
    model_write(4'b0000, '0, 8'h81);
    check_ctrl("R10 first data kept");

    // R11 unknown code
    access(4'b0010, '0, 1, 8'hFF, 0, rd, oe); check_ctrl("R11 unknown write");
    access(4'b0010, '0, 0, 0, 0, rd, oe); check("R11 unknown read oe", oe, 1'b0);

    // random mix
    for (int n = 0; n < 120; n++) begin
      logic [3:0] code;
      logic [12:0] blk;
      bit wr;
      logic [7:0] d;
      int r;
      r = $urandom_range(0, 9);
      code = (r < 6) ? CODES[r] : 4'($urandom_range(0, 15));
      blk = ($urandom_range(0, 4) == 0) ? (($urandom_range(0, 1) == 0) ? BLK_DEV0 : BLK_DEV1) : '0;
      wr = $urandom_range(0, 1);
      d = 8'($urandom);
      {dev1_stat, dev0_stat} = 8'($urandom);
      crate_stat = 4'($urandom); dac_last = 1'($urandom);
      cfg_init = 2'($urandom); cfg_busy = 2'($urandom); cfg_done = 2'($urandom);
      access(code, blk, wr, d, 0, rd, oe);
      if (wr) begin
        model_write(code, blk, d);
        check_ctrl("R6 random write");
      end else begin
        check("R5 random read oe", oe, (blk == '0) && known(code));
        if (blk == '0 && known(code)) check("R3 random read data", rd, exp_read(code));
      end
    end

    // R12 mid-run reset
    access(4'b1010, '0, 1, 8'h00, 0, rd, oe);
    model_write(4'b1010, '0, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) exp_c[i] = RSTV[i];
    check_ctrl("R12 mid-run reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_ctrl("R12 after release");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule